// File: doc/BRIEF.md
# Two-Output Interrupt Concentrator with Vector Readout

This block gathers sixteen level-sensitive device request lines into two CPU interrupt outputs. The fifteen lowest lines share one output. The top line has an output of its own. A registered copy of the inputs, the pending register, follows the raw lines one clock behind. A software-writable enable mask can drive either output on or off whenever a mask write changes that output's masked state.

Software uses a small register bus with an address, write and read strobes, and write and read data. Offset 0 holds the enable mask, which can be read and written. Offset 4 returns an encoded vector for the lowest-numbered pending shared line. Any access to offset 4, read or write, also pulls the shared output low. The output then stays low until a shared line newly becomes pending or a mask write raises the output again. Each output is a flop. The events that move it are applied in a fixed priority order.

Top module: `irq_concentrator`

## Requirements
- R1: The shared output rises on the clock after any of lines 0..14 newly goes high (high on the input while its pending bit is low). It falls on the clock after all of lines 0..14 go low while at least one was pending. This holds regardless of the enable mask.
- R2: The solo output rises on the clock after line 15 newly goes high and falls on the clock after line 15 drops. It is never affected by lines 0..14.
- R3: A read of offset 0 returns the last value written to offset 0, in bits 15..0, with the upper bits zero.
- R4: A write to offset 0 compares, for each output, the OR of (pending AND mask) over that output's lines before and after the write. If that state changed, the output takes the new state on the next clock, overriding a simultaneous request rise or fall. If it did not change, the mask write leaves that output as it was.
- R5: A read of offset 4 returns ((i+1) << 2), where i is the lowest index in 0..14 whose pending bit is set. It returns 0 when none of lines 0..14 is pending. The mask and line 15 play no part in the result.
- R6: Any read or write at offset 4 drives the shared output low on the next clock. This overrides a request rise in the same cycle. The solo output and the mask are unchanged by it.
- R7: The pending register equals the request inputs sampled at the previous clock, so a line that drops is no longer reported by the vector.
- R8: Reads of any offset other than 0 and 4 return zero. Writes to offsets other than 0 leave the mask unchanged.
- R9: Reset clears the pending register, the mask, both outputs and the read data.
- R10: Read data is registered: it shows the read result on the clock after the read strobe and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register byte offset |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Registered read data |
| reqIn | input | LINE_CNT | Raw level-sensitive request lines |
| irqShared | output | 1 | CPU interrupt for lines 0..LINE_CNT-2 |
| irqSolo | output | 1 | CPU interrupt for line LINE_CNT-1 |

## Verification
Two functions can fall in the same cycle and fight over the shared output: the clearing side effect of a vector access and the assertion caused by a request line newly going high. The bench provokes this by raising a fresh line on the same clock edge as a vector read. It judges the result by expecting the shared output low afterwards and still low while that line stays held. The read data in that case must show the vector of the pending state from before the edge. A similar overlap between a mask write and an unchanged masked state is judged by expecting the output to hold its previous value.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // register byte offsets; the vector offset carries a read side effect
  localparam int unsigned MASK_OFS = 0;
  localparam int unsigned VEC_OFS  = 4;

  // decoded bus actions handed from control to datapath
  typedef struct packed {
    logic maskWr;    // write to the enable mask
    logic maskRd;    // read of the enable mask
    logic vecRd;     // read of the vector
    logic vecTouch;  // any access at the vector offset
    logic zeroRd;    // read of an unmapped offset
  } busStrobes_t;

endpackage

// File: rtl/irqc_vec_enc.sv
module irqc_vec_enc #(
  parameter int unsigned LINES  = 15,
  parameter int unsigned OUT_W  = 32,
  parameter int unsigned SHIFT  = 2
) (
  input  logic [LINES-1:0] lines,
  output logic [OUT_W-1:0] vector
);

  // descending scan: the last hit written is the lowest set index
  always_comb begin
    vector = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (lines[i]) vector = OUT_W'((i + 1) << SHIFT);
    end
  end

endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output busStrobes_t       strobes
);

  logic hitMask;
  logic hitVec;

  assign hitMask = (regAddr == ADDR_W'(MASK_OFS));
  assign hitVec  = (regAddr == ADDR_W'(VEC_OFS));

  always_comb begin
    strobes          = '0;
    strobes.maskWr   = regWrEn && hitMask;
    strobes.maskRd   = regRdEn && hitMask;
    strobes.vecRd    = regRdEn && hitVec;
    strobes.vecTouch = (regRdEn || regWrEn) && hitVec;
    strobes.zeroRd   = regRdEn && !hitMask && !hitVec;
  end

endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int unsigned LINE_CNT = 16,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [LINE_CNT-1:0] reqIn,
  input  logic [DATA_W-1:0]   regWrData,
  input  busStrobes_t         strobes,
  output logic [DATA_W-1:0]   regRdData,
  output logic                irqShared,
  output logic                irqSolo
);

  localparam int unsigned LOW_CNT = LINE_CNT - 1;
  localparam int unsigned TOP_IDX = LINE_CNT - 1;

  logic [LINE_CNT-1:0] pendReg;
  logic [LINE_CNT-1:0] maskReg;
  logic [LINE_CNT-1:0] maskNew;
  logic [DATA_W-1:0]   vecVal;

  logic oldMaskedLow, newMaskedLow, chgLow, riseLow, fallLow;
  logic oldMaskedTop, newMaskedTop, chgTop, riseTop, fallTop;

  irqc_vec_enc #(
    .LINES (LOW_CNT),
    .OUT_W (DATA_W),
    .SHIFT (2)
  ) u_enc (
    .lines  (pendReg[LOW_CNT-1:0]),
    .vector (vecVal)
  );

  assign maskNew = regWrData[LINE_CNT-1:0];

  // masked state before and after a mask write
  assign oldMaskedLow = |(pendReg[LOW_CNT-1:0] & maskReg[LOW_CNT-1:0]);
  assign newMaskedLow = |(pendReg[LOW_CNT-1:0] & maskNew[LOW_CNT-1:0]);
  assign chgLow       = strobes.maskWr && (oldMaskedLow != newMaskedLow);
  assign oldMaskedTop = pendReg[TOP_IDX] & maskReg[TOP_IDX];
  assign newMaskedTop = pendReg[TOP_IDX] & maskNew[TOP_IDX];
  assign chgTop       = strobes.maskWr && (oldMaskedTop != newMaskedTop);

  // request events seen as the pending register is about to update
  assign riseLow = |(reqIn[LOW_CNT-1:0] & ~pendReg[LOW_CNT-1:0]);
  assign fallLow = (|pendReg[LOW_CNT-1:0]) && !(|reqIn[LOW_CNT-1:0]);
  assign riseTop = reqIn[TOP_IDX] && !pendReg[TOP_IDX];
  assign fallTop = !reqIn[TOP_IDX] && pendReg[TOP_IDX];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendReg <= '0;
      maskReg <= '0;
    end else begin
      pendReg <= reqIn;
      if (strobes.maskWr) maskReg <= maskNew;
    end
  end

  // shared output: vector access > mask change > fall > rise > hold
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqShared <= 1'b0;
    end else if (strobes.vecTouch) begin
      irqShared <= 1'b0;
    end else if (chgLow) begin
      irqShared <= newMaskedLow;
    end else if (fallLow) begin
      irqShared <= 1'b0;
    end else if (riseLow) begin
      irqShared <= 1'b1;
    end
  end

  // solo output: mask change > fall > rise > hold
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqSolo <= 1'b0;
    end else if (chgTop) begin
      irqSolo <= newMaskedTop;
    end else if (fallTop) begin
      irqSolo <= 1'b0;
    end else if (riseTop) begin
      irqSolo <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdData <= '0;
    end else if (strobes.maskRd) begin
      regRdData <= DATA_W'(maskReg);
    end else if (strobes.vecRd) begin
      regRdData <= vecVal;
    end else if (strobes.zeroRd) begin
      regRdData <= '0;
    end
  end

  // R7: pending register tracks inputs one clock late
  a_r7_pend_follows: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> pendReg == $past(reqIn));

  // R6: vector access leaves the shared output low
  a_r6_vec_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobes.vecTouch |=> !irqShared);

  // R3: mask holds the written value
  a_r3_mask_written: assert property (@(posedge clk) disable iff (!rstN)
    strobes.maskWr |=> maskReg == $past(maskNew));

  // R5: a vector read yields a multiple of four within range
  a_r5_vec_range: assert property (@(posedge clk) disable iff (!rstN)
    strobes.vecRd |=> (regRdData[1:0] == 2'b00) &&
                      (regRdData <= DATA_W'(LOW_CNT * 4)));

  // R8: unmapped read returns zero
  a_r8_zero_read: assert property (@(posedge clk) disable iff (!rstN)
    strobes.zeroRd |=> regRdData == '0);

  // R2: solo output only rises from a line rise or a mask write
  a_r2_solo_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqSolo) |-> $past(riseTop || strobes.maskWr));

  // R10: read data holds without a read
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.maskRd || strobes.vecRd || strobes.zeroRd) |=> $stable(regRdData));

endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator
  import irqc_pkg::*;
#(
  parameter int unsigned LINE_CNT = 16,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic [LINE_CNT-1:0] reqIn,
  output logic                irqShared,
  output logic                irqSolo
);

  busStrobes_t strobes;

  irqc_ctrl #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .strobes (strobes)
  );

  irqc_datapath #(
    .LINE_CNT (LINE_CNT),
    .DATA_W   (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reqIn     (reqIn),
    .regWrData (regWrData),
    .strobes   (strobes),
    .regRdData (regRdData),
    .irqShared (irqShared),
    .irqSolo   (irqSolo)
  );

endmodule

// File: tb/irq_concentrator_tb.sv
module irq_concentrator_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [15:0] reqIn = '0;
  logic        irqShared;
  logic        irqSolo;

  int checkCount = 0;
  int failCount  = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_concentrator u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .reqIn     (reqIn),
    .irqShared (irqShared),
    .irqSolo   (irqSolo)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic setReq(input logic [15:0] v);
    reqIn = v;
    @(negedge clk);
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual expired expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9: reset state
    check("R9 shared", 32'(irqShared), 0);
    check("R9 solo", 32'(irqSolo), 0);
    check("R9 rdData", regRdData, 0);
    busRead(8'h00, rd); check("R9 mask", rd, 0);
    busRead(8'h04, rd); check("R9 vector", rd, 0);

    // R3: mask readback sweep, one bit and patterns
    for (int i = 0; i < 16; i++) begin
      busWrite(8'h00, 32'hFFFF_0000 | (32'h1 << i));
      busRead(8'h00, rd);
      check("R3 mask bit", rd, 32'h1 << i);
    end
    busWrite(8'h00, 32'h0000_A5C3); busRead(8'h00, rd); check("R3 mask pat", rd, 32'hA5C3);
    busWrite(8'h00, 32'h0);         busRead(8'h00, rd); check("R3 mask zero", rd, 0);

    // R5/R7: vector sweep, lowest pending line wins, line 15 excluded
    for (int i = 0; i <= 16; i++) begin
      setReq(16'(32'hFFFF << i));
      busRead(8'h04, rd);
      check("R5 vector", rd, (i < 15) ? 32'((i + 1) * 4) : 32'h0);
    end
    setReq(16'h0010); setReq(16'h0000);
    busRead(8'h04, rd); check("R7 dropped line", rd, 0);

    // R10: read data holds across idle cycles and writes
    busRead(8'h00, rd);
    busWrite(8'h00, 32'h3);
    repeat (3) @(negedge clk);
    check("R10 hold", regRdData, 0);
    busWrite(8'h00, 32'h0);

    // R1/R2: each line drives its own output, mask zero
    for (int i = 0; i < 16; i++) begin
      setReq(16'(1 << i));
      check("R1 shared on", 32'(irqShared), (i < 15) ? 1 : 0);
      check("R2 solo on", 32'(irqSolo), (i == 15) ? 1 : 0);
      setReq(16'h0);
      check("R1 shared off", 32'(irqShared), 0);
      check("R2 solo off", 32'(irqSolo), 0);
    end

    // R6: vector access clears shared output and keeps it low
    setReq(16'h8008);
    check("R6 pre shared", 32'(irqShared), 1);
    busRead(8'h04, rd);
    check("R6 vec read", rd, 32'd16);
    check("R6 cleared", 32'(irqShared), 0);
    check("R6 solo kept", 32'(irqSolo), 1);
    @(negedge clk);
    check("R6 stays low", 32'(irqShared), 0);
    setReq(16'h8028);
    check("R6 new rise", 32'(irqShared), 1);
    busWrite(8'h04, 32'hFFFF);
    check("R6 write clears", 32'(irqShared), 0);
    busRead(8'h00, rd);
    check("R8 vec write no mask", rd, 0);

    // R6: vector access in the same cycle as a new request
    setReq(16'h0000);
    reqIn = 16'h0040;
    busRead(8'h04, rd);
    check("R6 same-cycle vec", rd, 0);
    check("R6 same-cycle shared", 32'(irqShared), 0);
    @(negedge clk);
    check("R6 same-cycle held", 32'(irqShared), 0);
    busRead(8'h04, rd);
    check("R7 pending seen", rd, 32'd28);

    // R4: mask-driven changes on the shared output
    setReq(16'h0000);
    setReq(16'h0004);
    busRead(8'h04, rd);
    check("R4 cleared first", 32'(irqShared), 0);
    busWrite(8'h00, 32'h0080);
    check("R4 unchanged low", 32'(irqShared), 0);
    busWrite(8'h00, 32'h0004);
    check("R4 masked rise", 32'(irqShared), 1);
    busWrite(8'h00, 32'h0084);
    check("R4 unchanged high", 32'(irqShared), 1);
    busWrite(8'h00, 32'h0000);
    check("R4 masked fall", 32'(irqShared), 0);
    busWrite(8'h00, 32'h0004);
    busRead(8'h04, rd);
    busWrite(8'h00, 32'h0005);
    check("R4 hold after clear", 32'(irqShared), 0);

    // R4: mask-driven changes on the solo output
    busWrite(8'h00, 32'h0);
    setReq(16'h8000);
    check("R2 solo up", 32'(irqSolo), 1);
    busWrite(8'h00, 32'h8000);
    check("R4 solo no change", 32'(irqSolo), 1);
    busWrite(8'h00, 32'h0000);
    check("R4 solo masked fall", 32'(irqSolo), 0);
    busWrite(8'h00, 32'h8000);
    check("R4 solo masked rise", 32'(irqSolo), 1);

    // R8: unmapped reads and writes
    busRead(8'h08, rd); check("R8 unmapped 8", rd, 0);
    busWrite(8'h0C, 32'h1234);
    busRead(8'h0C, rd); check("R8 unmapped C", rd, 0);
    busRead(8'h00, rd); check("R8 mask intact", rd, 32'h8000);

    // R9: reset mid-run clears everything
    rstN = 1'b0;
    @(negedge clk);
    reqIn = '0;
    rstN = 1'b1;
    @(negedge clk);
    check("R9 shared again", 32'(irqShared), 0);
    check("R9 solo again", 32'(irqSolo), 0);
    busRead(8'h00, rd); check("R9 mask again", rd, 0);

    finishRun();
  end

endmodule